// File: doc/BRIEF.md
# Freezable DC Offset Removal Filter

This block strips the DC component from parallel channels of signed audio samples. Each channel keeps its own fixed-point estimate of the DC level. The estimate is a first-order low-pass of the input, built from a shift rather than a multiplier. The integer part of that estimate is subtracted from every incoming sample, and the result is clipped to the sample range. The net effect is a first-order high-pass response. With the default shift of 13, the corner sits near 0.9 Hz at a 48 kHz sample rate, and it moves in proportion to the sample rate.

A shared hold input stops the estimate from tracking, but the held value is still subtracted. A system-level calibration uses this. The signal source is grounded, the filter runs until it settles (about a second of samples), and then hold is raised. The captured offset is then removed from every later sample for as long as hold stays high. When hold is dropped, tracking resumes from the held value.

Top module: `dcrm_filter`

## Requirements
- R1: After reset, `out_valid` and `out_data` are zero and every channel's DC estimate is zero, so the first sample leaves the block unchanged.
- R2: `out_valid` goes high exactly one clock after a cycle with `in_valid` high and is low otherwise. `out_data` keeps its last value in every cycle that follows a clock with `in_valid` low.
- R3: For each accepted sample x, the output is clip(x - off), where off is the channel's integer estimate as it stood before that sample's update.
- R4: On an accepted sample with `hold_dc` low, the scaled estimate A (the DC level times 2^FRAC_W) is updated as A := A + floor((x*2^FRAC_W - A) / 2^K_SHIFT). The default is FRAC_W = K_SHIFT = 13.
- R5: The integer estimate off is floor(A / 2^FRAC_W).
- R6: While `hold_dc` is high, A does not change, and the frozen integer estimate is still subtracted from every sample.
- R7: Cycles with `in_valid` low never change A, whatever `in_data` and `hold_dc` carry.
- R8: The clip maps any difference outside [-2^(DATA_W-1), 2^(DATA_W-1)-1] to the nearer end, and the output sign always matches the sign of x - off.
- R9: Channel c uses bits [c*DATA_W +: DATA_W] of `in_data` and `out_data`, and each channel has its own estimate.
- R10: When `hold_dc` falls, tracking continues from the held estimate, with no reset of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe for all channels |
| in_data | input | NUM_CH*DATA_W | Signed input samples, channel c at [c*DATA_W +: DATA_W] |
| hold_dc | input | 1 | High: freeze DC estimates but keep subtracting them |
| out_valid | output | 1 | Corrected sample strobe, one clock after in_valid |
| out_data | output | NUM_CH*DATA_W | Signed corrected samples, same lane layout |

## Verification
Some properties are checked by assertions on every clock. These are:
- the one-cycle strobe latency and the holding of the output between samples;
- the estimate staying still under hold;
- each tracking step landing between the old estimate and the new sample;
- no overflow of the internal sum;
- the output sign agreeing with the sign of the unclipped difference.

The exact arithmetic of the update and the subtraction is left to the bench scenarios. So are the settling towards a constant input, the value captured by a freeze, clipping at both ends, the resumption after hold falls and the separation of the channels.

// File: rtl/dcrm_pkg.sv
package dcrm_pkg;
  localparam int unsigned DEF_DATA_W  = 24;
  localparam int unsigned DEF_FRAC_W  = 13;
  localparam int unsigned DEF_K_SHIFT = 13;
  localparam int unsigned DEF_NUM_CH  = 2;

  typedef enum logic {
    TRACK_DC = 1'b0,
    HOLD_DC  = 1'b1
  } dc_mode_e;
endpackage

// File: rtl/dcrm_rst_sync.sv
module dcrm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/dcrm_dc_track.sv
module dcrm_dc_track
  import dcrm_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned FRAC_W  = DEF_FRAC_W,
  parameter int unsigned K_SHIFT = DEF_K_SHIFT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] smp,
  input  logic                     hold,
  output logic signed [DATA_W-1:0] dc_int
);
  localparam int unsigned ACC_W = DATA_W + FRAC_W;

  dc_mode_e                mode;
  logic                    upd_en;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_d;
  logic signed [ACC_W:0]   acc_ext;
  logic signed [ACC_W:0]   x_ext;
  logic signed [ACC_W:0]   diff;
  logic signed [ACC_W:0]   step;
  logic signed [ACC_W:0]   acc_sum;

  always_comb begin
    mode    = hold ? HOLD_DC : TRACK_DC;
    upd_en  = smp_valid && (mode == TRACK_DC);
    acc_ext = {acc_q[ACC_W-1], acc_q};
    x_ext   = {smp[DATA_W-1], smp, {FRAC_W{1'b0}}};
    diff    = x_ext - acc_ext;
    step    = diff >>> K_SHIFT;
    acc_sum = acc_ext + step;
    acc_d   = acc_sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (upd_en) acc_q <= acc_d;
  end

  assign dc_int = acc_q[ACC_W-1:FRAC_W];

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold) || !$past(smp_valid)) |-> $stable(acc_q));

  p_step_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(upd_en) |->
      ((acc_ext >= $past(acc_ext) && acc_ext <= $past(x_ext)) ||
       (acc_ext <= $past(acc_ext) && acc_ext >= $past(x_ext))));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> (acc_sum[ACC_W] == acc_sum[ACC_W-1]));
endmodule

// File: rtl/dcrm_sub_sat.sv
module dcrm_sub_sat #(
  parameter int unsigned DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] smp,
  input  logic signed [DATA_W-1:0] dc_int,
  output logic signed [DATA_W-1:0] y
);
  localparam logic signed [DATA_W-1:0] Y_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] Y_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W:0]   wide;
  logic signed [DATA_W-1:0] y_d;

  always_comb begin
    wide = {smp[DATA_W-1], smp} - {dc_int[DATA_W-1], dc_int};
    if (wide[DATA_W] != wide[DATA_W-1])
      y_d = wide[DATA_W] ? Y_MIN : Y_MAX;
    else
      y_d = wide[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         y <= '0;
    else if (smp_valid) y <= y_d;
  end

  p_sign_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_valid) |-> (y[DATA_W-1] == ($past(smp) < $past(dc_int))));

  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_valid) |-> $stable(y));
endmodule

// File: rtl/dcrm_filter.sv
module dcrm_filter
  import dcrm_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned FRAC_W  = DEF_FRAC_W,
  parameter int unsigned K_SHIFT = DEF_K_SHIFT,
  parameter int unsigned NUM_CH  = DEF_NUM_CH
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [NUM_CH*DATA_W-1:0] in_data,
  input  logic                     hold_dc,
  output logic                     out_valid,
  output logic [NUM_CH*DATA_W-1:0] out_data
);
  localparam int unsigned BUS_W = NUM_CH * DATA_W;

  logic             rst_n_s;
  logic             vld_q;
  logic             vld_d;
  logic [BUS_W-1:0] y_bus;

  dcrm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    logic signed [DATA_W-1:0] x_c;
    logic signed [DATA_W-1:0] dc_c;
    logic signed [DATA_W-1:0] y_c;

    assign x_c = in_data[c*DATA_W +: DATA_W];

    dcrm_dc_track #(
      .DATA_W  (DATA_W),
      .FRAC_W  (FRAC_W),
      .K_SHIFT (K_SHIFT)
    ) u_track (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .smp_valid (in_valid),
      .smp       (x_c),
      .hold      (hold_dc),
      .dc_int    (dc_c)
    );

    dcrm_sub_sat #(.DATA_W(DATA_W)) u_sub (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .smp_valid (in_valid),
      .smp       (x_c),
      .dc_int    (dc_c),
      .y         (y_c)
    );

    assign y_bus[c*DATA_W +: DATA_W] = y_c;
  end

  always_comb begin
    vld_d = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) vld_q <= 1'b0;
    else          vld_q <= vld_d;
  end

  assign out_valid = vld_q;
  assign out_data  = y_bus;

  p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(rst_n_s) |-> (out_valid == $past(in_valid)));
endmodule

// File: tb/sim_dcrm_filter.sv
module sim_dcrm_filter;
  localparam int W  = 24;
  localparam int NC = 2;
  localparam int FR = 13;
  localparam int KS = 13;
  localparam longint YMAX = (64'sd1 <<< (W-1)) - 1;
  localparam longint YMIN = -(64'sd1 <<< (W-1));

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [NC*W-1:0] in_data = '0;
  logic            hold_dc = 1'b0;
  logic            out_valid;
  logic [NC*W-1:0] out_data;

  int     checks = 0;
  int     errors = 0;
  bit     done = 0;
  longint m_acc [NC];
  longint last_y [NC];

  always #10 clk = ~clk;

  dcrm_filter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .hold_dc(hold_dc), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic longint clip(longint v);
    if (v > YMAX) return YMAX;
    if (v < YMIN) return YMIN;
    return v;
  endfunction

  function automatic longint lane(int c);
    logic signed [W-1:0] t;
    t = out_data[c*W +: W];
    return longint'(t);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(longint x0, longint x1, bit hold, string req);
    longint xs [NC];
    longint e;
    xs[0] = x0; xs[1] = x1;
    @(negedge clk);
    in_valid = 1'b1;
    hold_dc  = hold;
    in_data  = {x1[W-1:0], x0[W-1:0]};
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R2 valid", longint'(out_valid), 1);
    for (int c = 0; c < NC; c++) begin
      e = clip(xs[c] - (m_acc[c] >>> FR));
      chk(lane(c) == e, req, lane(c), e);
      last_y[c] = lane(c);
      if (!hold) m_acc[c] = m_acc[c] + (((xs[c] <<< FR) - m_acc[c]) >>> KS);
    end
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
    chk(out_data == '0, "R1 data", longint'(out_data), 0);
  endtask

  task automatic t_first();
    send(123456, -654321, 1'b0, "R1 R3 first sample");
  endtask

  task automatic t_settle();
    for (int i = 0; i < 20000; i++) send(1000000, -1000000, 1'b0, "R4 R5 R9 settle");
    chk(lane(0) < 100000 && lane(0) > 0, "R4 decay ch0", lane(0), 87000);
    chk(lane(1) > -100000 && lane(1) < 0, "R4 decay ch1", lane(1), -87000);
  endtask

  task automatic t_freeze();
    longint first0;
    send(0, 0, 1'b1, "R6 freeze");
    first0 = lane(0);
    for (int i = 0; i < 50; i++) send(0, 0, 1'b1, "R6 held");
    chk(lane(0) == first0, "R6 stable", lane(0), first0);
    for (int i = 0; i < 20; i++)
      send(longint'($urandom_range(0, 400000)) - 200000, 5000, 1'b1, "R6 subtract");
  endtask

  task automatic t_saturate();
    send(YMIN, YMAX, 1'b1, "R8 clip");
    chk(lane(0) == YMIN, "R8 low end", lane(0), YMIN);
    chk(lane(1) == YMAX, "R8 high end", lane(1), YMAX);
    send(YMAX, YMIN, 1'b1, "R8 no clip");
  endtask

  task automatic t_idle();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_data = {24'h7abcde, 24'h812345};
      hold_dc = i[0];
      @(negedge clk);
      chk(out_valid == 1'b0, "R2 idle valid", longint'(out_valid), 0);
      chk(lane(0) == last_y[0], "R2 hold data", lane(0), last_y[0]);
    end
    send(0, 0, 1'b1, "R7 no update when idle");
  endtask

  task automatic t_resume();
    for (int i = 0; i < 200; i++)
      send(longint'($urandom_range(0, 2000000)) - 1000000, 300000, 1'b0, "R10 resume");
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin m_acc[c] = 0; last_y[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_first();
    t_settle();
    t_freeze();
    t_saturate();
    t_idle();
    t_resume();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule